// File: doc/BRIEF.md
# Sequential Quadratic Discriminant Unit

This block evaluates `b*b - 4*a*c` for one set of signed operands at a time. The caller raises `arg_vld` for one cycle with `a`, `b` and `c`, then waits for the one-cycle `res_vld` pulse. Only after that pulse may it present the next set. Internally a controller time-shares exactly one multiplier and one subtractor. Both are opaque pipelined units, and the controller reaches them only through their valid/data ports. Their latencies are parameters, so the total latency follows from the chosen schedule.

The constant four enters the multiplier as an ordinary operand. The products formed are `4*a`, `(4*a)*c` and `b*b`, and one subtraction follows them. The parameter `OVERLAP` selects between two schedules. The default sequential schedule makes no assumption that the multiplier is pipelined: it waits for each product before it issues the next. The overlapped schedule issues `4*a` and `b*b` on consecutive cycles. This needs one fewer controller state and finishes sooner.

Top module: `quad_disc_seq`

## Requirements
- R1: `res` equals `b*b - 4*a*c`, computed exactly from the signed `W`-bit operands and given as a signed `2*W+3`-bit value.
- R2: With `OVERLAP=0`, `res_vld` rises 5+3·MUL_LAT+SUB_LAT cycles after the cycle in which `arg_vld` was accepted. This is 16 cycles with the default latencies. The multiplier never holds more than one operation in flight.
- R3: With `OVERLAP=1` and MUL_LAT ≥ 2, `res_vld` rises 4+2·MUL_LAT+SUB_LAT cycles after acceptance. This is 12 cycles with the default latencies.
- R4: `res_vld` is high for exactly one cycle per accepted operand set.
- R5: `res` changes only in a cycle where `res_vld` is high and holds its value until the next result.
- R6: An `arg_vld` that arrives while a computation is in progress is ignored. It does not alter the running result and does not produce an extra `res_vld`.
- R7: While reset is asserted, and after it until the first result, `res_vld` is low and `res` is zero.
- R8: A new operand set presented in the same cycle that `res_vld` is high is accepted, and it completes with the normal latency and value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arg_vld | input | 1 | Operand strobe, one cycle |
| a | input | W | Signed quadratic coefficient |
| b | input | W | Signed linear coefficient |
| c | input | W | Signed constant term |
| res_vld | output | 1 | One-cycle result strobe |
| res | output | 2*W+3 | Signed discriminant, held between strobes |

## Verification
With default latencies the sequential instance must pulse `res_vld` exactly 16 clock edges after the edge that accepts `arg_vld`, and the overlapped instance exactly 12. The bench drives operands on the falling edge and counts falling edges until the pulse, so it compares the count against the formula and reads the value in that same half-cycle. The next falling edge must show the strobe low. A further window of falling edges must show `res` unchanged and, after an ignored mid-flight strobe, no second pulse.

// File: rtl/quad_disc_pkg.sv
package quad_disc_pkg;

  // Controller states; the overlapped schedule never visits ST_WAIT_B
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ISS_4A,
    ST_ISS_BB,
    ST_ISS_4AC,
    ST_WAIT_A,
    ST_WAIT_B,
    ST_WAIT_C,
    ST_SUB,
    ST_WAIT_S
  } state_e;

  // Which operand pair drives the multiplier
  typedef enum logic [1:0] {
    OPS_NONE,
    OPS_4A,
    OPS_4AC,
    OPS_BB
  } opsel_e;

  // Which holding register receives the returning product
  typedef enum logic [1:0] {
    SLOT_4A,
    SLOT_4AC,
    SLOT_BB,
    SLOT_NONE
  } slot_e;

  localparam int unsigned CONST_FOUR = 4;

  // Products return in issue order; that order depends on the schedule
  function automatic slot_e slot_for(input logic [1:0] idx, input bit overlap);
    slot_e s;
    case (idx)
      2'd0:    s = SLOT_4A;
      2'd1:    s = overlap ? SLOT_BB  : SLOT_4AC;
      2'd2:    s = overlap ? SLOT_4AC : SLOT_BB;
      default: s = SLOT_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/quad_disc_arith.sv
// Opaque arithmetic unit: valid-in, valid-out after LAT cycles.
module quad_disc_arith #(
  parameter int unsigned RW     = 19,
  parameter int unsigned LAT    = 3,
  parameter bit          IS_SUB = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [RW-1:0] x,
  input  logic signed [RW-1:0] y,
  output logic                 out_vld,
  output logic signed [RW-1:0] z
);

  logic signed [RW-1:0] op_res;
  logic [LAT-1:0]       pv;
  logic signed [RW-1:0] pd [LAT];

  generate
    if (IS_SUB) begin : g_sub
      assign op_res = x - y;
    end else begin : g_mul
      assign op_res = x * y;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
    end else begin
      pv[0] <= in_vld;
      for (int i = 1; i < LAT; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) pd[0] <= op_res;
    for (int i = 1; i < LAT; i++) begin
      if (pv[i-1]) pd[i] <= pd[i-1];
    end
  end

  assign out_vld = pv[LAT-1];
  assign z       = pd[LAT-1];

endmodule

// File: rtl/quad_disc_ctrl.sv
module quad_disc_ctrl
  import quad_disc_pkg::*;
#(
  parameter bit OVERLAP = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   arg_vld,
  input  logic   mul_ov,
  input  logic   sub_ov,
  output logic   busy,
  output logic   ld_args,
  output logic   mul_iv,
  output opsel_e op_sel,
  output logic   cap_vld,
  output slot_e  cap_slot,
  output logic   sub_iv
);

  state_e     st, st_n;
  logic [1:0] ret_cnt;

  assign busy     = (st != ST_IDLE);
  assign ld_args  = (st == ST_IDLE) && arg_vld;
  assign cap_vld  = mul_ov;
  assign cap_slot = slot_for(ret_cnt, OVERLAP);

  always_comb begin
    st_n   = st;
    mul_iv = 1'b0;
    op_sel = OPS_NONE;
    sub_iv = 1'b0;
    case (st)
      ST_IDLE: if (arg_vld) st_n = ST_ISS_4A;
      ST_ISS_4A: begin
        mul_iv = 1'b1;
        op_sel = OPS_4A;
        st_n   = OVERLAP ? ST_ISS_BB : ST_WAIT_A;
      end
      ST_ISS_BB: begin
        mul_iv = 1'b1;
        op_sel = OPS_BB;
        st_n   = OVERLAP ? ST_WAIT_A : ST_WAIT_C;
      end
      ST_WAIT_A: begin
        if (mul_ov || (OVERLAP && ret_cnt != 2'd0)) st_n = ST_ISS_4AC;
      end
      ST_ISS_4AC: begin
        mul_iv = 1'b1;
        op_sel = OPS_4AC;
        st_n   = OVERLAP ? ST_WAIT_C : ST_WAIT_B;
      end
      ST_WAIT_B: if (mul_ov) st_n = ST_ISS_BB;
      ST_WAIT_C: if (mul_ov && ret_cnt == 2'd2) st_n = ST_SUB;
      ST_SUB: begin
        sub_iv = 1'b1;
        st_n   = ST_WAIT_S;
      end
      ST_WAIT_S: if (sub_ov) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_cnt <= 2'd0;
    else if (ld_args) ret_cnt <= 2'd0;
    else if (mul_ov)  ret_cnt <= ret_cnt + 2'd1;
  end

endmodule

// File: rtl/quad_disc_dp.sv
module quad_disc_dp
  import quad_disc_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned RW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_args,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  input  logic signed [W-1:0]  c,
  input  opsel_e               op_sel,
  input  logic                 cap_vld,
  input  slot_e                cap_slot,
  input  logic signed [RW-1:0] mul_p,
  input  logic                 sub_ov,
  input  logic signed [RW-1:0] sub_d,
  output logic signed [RW-1:0] mul_x,
  output logic signed [RW-1:0] mul_y,
  output logic signed [RW-1:0] sub_x,
  output logic signed [RW-1:0] sub_y,
  output logic signed [W-1:0]  ra_q,
  output logic                 res_vld,
  output logic signed [RW-1:0] res
);

  localparam int unsigned EXT = RW - W;
  localparam logic signed [RW-1:0] FOUR = RW'(CONST_FOUR);

  logic signed [W-1:0]  rb_q, rc_q;
  logic signed [RW-1:0] p4a_q, p4ac_q, pbb_q;
  logic signed [RW-1:0] ea, eb, ec;

  assign ea = {{EXT{ra_q[W-1]}}, ra_q};
  assign eb = {{EXT{rb_q[W-1]}}, rb_q};
  assign ec = {{EXT{rc_q[W-1]}}, rc_q};

  always_ff @(posedge clk) begin
    if (ld_args) begin
      ra_q <= a;
      rb_q <= b;
      rc_q <= c;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_vld) begin
      case (cap_slot)
        SLOT_4A:  p4a_q  <= mul_p;
        SLOT_4AC: p4ac_q <= mul_p;
        SLOT_BB:  pbb_q  <= mul_p;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (op_sel)
      OPS_4A:  begin mul_x = FOUR;  mul_y = ea; end
      OPS_4AC: begin mul_x = p4a_q; mul_y = ec; end
      OPS_BB:  begin mul_x = eb;    mul_y = eb; end
      default: begin mul_x = '0;    mul_y = '0; end
    endcase
  end

  assign sub_x = pbb_q;
  assign sub_y = p4ac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= sub_ov;
      if (sub_ov) res <= sub_d;
    end
  end

endmodule

// File: rtl/quad_disc_seq.sv
module quad_disc_seq
  import quad_disc_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned MUL_LAT = 3,
  parameter int unsigned SUB_LAT = 2,
  parameter bit          OVERLAP = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arg_vld,
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  input  logic signed [W-1:0]   c,
  output logic                  res_vld,
  output logic signed [2*W+2:0] res
);

  localparam int unsigned RW = 2 * W + 3;

  logic [1:0]           rsync;
  logic                 srst_n;
  logic                 busy, ld_args, mul_iv, mul_ov, sub_iv, sub_ov, cap_vld;
  opsel_e               op_sel;
  slot_e                cap_slot;
  logic signed [RW-1:0] mul_x, mul_y, mul_p, sub_x, sub_y, sub_d;
  logic signed [W-1:0]  ra_q;

  // Reset: asserted at once, released two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  quad_disc_ctrl #(.OVERLAP(OVERLAP)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .arg_vld(arg_vld), .mul_ov(mul_ov),
    .sub_ov(sub_ov), .busy(busy), .ld_args(ld_args), .mul_iv(mul_iv),
    .op_sel(op_sel), .cap_vld(cap_vld), .cap_slot(cap_slot), .sub_iv(sub_iv)
  );

  quad_disc_dp #(.W(W), .RW(RW)) u_dp (
    .clk(clk), .rst_n(srst_n), .ld_args(ld_args), .a(a), .b(b), .c(c),
    .op_sel(op_sel), .cap_vld(cap_vld), .cap_slot(cap_slot), .mul_p(mul_p),
    .sub_ov(sub_ov), .sub_d(sub_d), .mul_x(mul_x), .mul_y(mul_y),
    .sub_x(sub_x), .sub_y(sub_y), .ra_q(ra_q), .res_vld(res_vld), .res(res)
  );

  quad_disc_arith #(.RW(RW), .LAT(MUL_LAT), .IS_SUB(1'b0)) u_mul (
    .clk(clk), .rst_n(srst_n), .in_vld(mul_iv), .x(mul_x), .y(mul_y),
    .out_vld(mul_ov), .z(mul_p)
  );

  quad_disc_arith #(.RW(RW), .LAT(SUB_LAT), .IS_SUB(1'b1)) u_sub (
    .clk(clk), .rst_n(srst_n), .in_vld(sub_iv), .x(sub_x), .y(sub_y),
    .out_vld(sub_ov), .z(sub_d)
  );

endmodule

// File: rtl/quad_disc_seq_chk.sv
module quad_disc_seq_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned MUL_LAT = 3,
  parameter int unsigned SUB_LAT = 2,
  parameter bit          OVERLAP = 1'b0
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic                  arg_vld,
  input logic signed [W-1:0]   a,
  input logic signed [W-1:0]   b,
  input logic signed [W-1:0]   c,
  input logic                  res_vld,
  input logic signed [2*W+2:0] res,
  input logic                  busy,
  input logic                  mul_iv,
  input logic                  mul_ov,
  input logic signed [W-1:0]   ra_q
);

  localparam int unsigned RW  = 2 * W + 3;
  localparam int unsigned EXT = RW - W;
  localparam int unsigned EXP_LAT = OVERLAP ? (4 + 2 * MUL_LAT + SUB_LAT)
                                            : (5 + 3 * MUL_LAT + SUB_LAT);

  logic signed [W-1:0]  ca, cb, cc;
  logic signed [RW-1:0] xa, xb, xc, exp_v;
  logic [15:0]          lat;
  logic [2:0]           outst;
  logic                 accept;

  assign accept = arg_vld && !busy;
  assign xa = {{EXT{ca[W-1]}}, ca};
  assign xb = {{EXT{cb[W-1]}}, cb};
  assign xc = {{EXT{cc[W-1]}}, cc};
  assign exp_v = xb * xb - RW'(4) * xa * xc;

  always_ff @(posedge clk) begin
    if (accept) begin
      ca <= a;
      cb <= b;
      cc <= c;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       lat <= '0;
    else if (accept)   lat <= 16'd1;
    else if (res_vld)  lat <= '0;
    else if (lat != 0) lat <= lat + 16'd1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) outst <= '0;
    else         outst <= outst + {2'b00, mul_iv} - {2'b00, mul_ov};
  end

  a_r1_value: assert property (@(posedge clk) disable iff (!srst_n)
    res_vld |-> res == exp_v);

  generate
    if (OVERLAP) begin : g_ovl
      if (MUL_LAT >= 2) begin : g_lat
        a_r3_latency: assert property (@(posedge clk) disable iff (!srst_n)
          res_vld |-> lat == 16'(EXP_LAT));
      end
    end else begin : g_seq
      a_r2_latency: assert property (@(posedge clk) disable iff (!srst_n)
        res_vld |-> lat == 16'(EXP_LAT));
      a_r2_single_flight: assert property (@(posedge clk) disable iff (!srst_n)
        mul_iv |-> outst == 3'd0);
    end
  endgenerate

  a_r4_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    res_vld |=> !res_vld);

  a_r5_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !res_vld |-> $stable(res));

  a_r6_ignore: assert property (@(posedge clk) disable iff (!srst_n)
    (arg_vld && busy) |=> $stable(ra_q));

endmodule

bind quad_disc_seq quad_disc_seq_chk #(
  .W(W), .MUL_LAT(MUL_LAT), .SUB_LAT(SUB_LAT), .OVERLAP(OVERLAP)
) u_chk (
  .clk(clk), .srst_n(srst_n), .arg_vld(arg_vld), .a(a), .b(b), .c(c),
  .res_vld(res_vld), .res(res), .busy(busy), .mul_iv(mul_iv),
  .mul_ov(mul_ov), .ra_q(ra_q)
);

// File: tb/quad_disc_seq_test.sv
`timescale 1ns/1ps
module quad_disc_seq_test;

  localparam int W  = 8;
  localparam int ML = 3;
  localparam int SL = 2;
  localparam int RW = 2 * W + 3;
  localparam int LAT_SEQ = 5 + 3 * ML + SL;
  localparam int LAT_OVL = 4 + 2 * ML + SL;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic                 av [2];
  logic signed [W-1:0]  xa [2];
  logic signed [W-1:0]  xb [2];
  logic signed [W-1:0]  xc [2];
  logic                 rv [2];
  logic signed [RW-1:0] rs [2];

  int n_cmp = 0;
  int n_bad = 0;

  quad_disc_seq #(.W(W), .MUL_LAT(ML), .SUB_LAT(SL), .OVERLAP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .arg_vld(av[0]), .a(xa[0]), .b(xb[0]), .c(xc[0]),
    .res_vld(rv[0]), .res(rs[0])
  );

  quad_disc_seq #(.W(W), .MUL_LAT(ML), .SUB_LAT(SL), .OVERLAP(1'b1)) uut_ov (
    .clk(clk), .rst_n(rst_n), .arg_vld(av[1]), .a(xa[1]), .b(xb[1]), .c(xc[1]),
    .res_vld(rv[1]), .res(rs[1])
  );

  function automatic longint ref_disc(longint a, longint b, longint c);
    return b * b - 4 * a * c;
  endfunction

  function automatic int exp_lat(int m);
    return (m == 0) ? LAT_SEQ : LAT_OVL;
  endfunction

  function automatic string lat_req(int m);
    return (m == 0) ? "R2" : "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Called at a falling edge; returns at the falling edge showing res_vld
  task automatic do_op(input int m, input logic signed [W-1:0] a,
                       input logic signed [W-1:0] b, input logic signed [W-1:0] c,
                       output int cyc, output longint val);
    xa[m] = a; xb[m] = b; xc[m] = c; av[m] = 1'b1;
    @(negedge clk);
    av[m] = 1'b0;
    cyc = 1;
    while (!rv[m] && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    val = rs[m];
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      av[m] = 1'b0; xa[m] = '0; xb[m] = '0; xc[m] = '0;
    end
    repeat (4) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(rv[m] == 1'b0, "R7", "res_vld in reset", longint'(rv[m]), 0);
      check(rs[m] == '0, "R7", "res in reset", rs[m], 0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(rv[m] == 1'b0, "R7", "res_vld after reset", longint'(rv[m]), 0);
      check(rs[m] == '0, "R7", "res after reset", rs[m], 0);
    end
  endtask

  task automatic t_values(input int m);
    logic signed [W-1:0] va [6] = '{8'sd1,  8'sd2,  -8'sd128, 8'sd127, 8'sd0,   -8'sd3};
    logic signed [W-1:0] vb [6] = '{8'sd5,  8'sd3,  -8'sd128, 8'sd0,   -8'sd7,  8'sd4};
    logic signed [W-1:0] vc [6] = '{8'sd6,  8'sd4,  8'sd127,  8'sd127, 8'sd100, -8'sd5};
    for (int i = 0; i < 6; i++) begin
      int cyc;
      longint val, expv;
      longint held;
      do_op(m, va[i], vb[i], vc[i], cyc, val);
      expv = ref_disc(va[i], vb[i], vc[i]);
      check(val == expv, "R1", "discriminant", val, expv);
      check(cyc == exp_lat(m), lat_req(m), "latency", cyc, exp_lat(m));
      held = val;
      @(negedge clk);
      check(rv[m] == 1'b0, "R4", "strobe width", longint'(rv[m]), 0);
      repeat (4) @(negedge clk);
      check(rs[m] == held, "R5", "result hold", rs[m], held);
    end
  endtask

  task automatic t_ignore(input int m);
    int cyc;
    int extra;
    xa[m] = 8'sd3; xb[m] = 8'sd9; xc[m] = 8'sd2; av[m] = 1'b1;
    @(negedge clk);
    av[m] = 1'b0;
    cyc = 1;
    repeat (3) begin @(negedge clk); cyc++; end
    xa[m] = 8'sd1; xb[m] = 8'sd1; xc[m] = 8'sd1; av[m] = 1'b1;
    @(negedge clk);
    cyc++;
    av[m] = 1'b0;
    while (!rv[m] && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(rs[m] == 57, "R6", "result after busy strobe", rs[m], 57);
    check(cyc == exp_lat(m), "R6", "latency after busy strobe", cyc, exp_lat(m));
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (rv[m]) extra++;
    end
    check(extra == 0, "R6", "extra result pulses", extra, 0);
    check(rs[m] == 57, "R6", "result kept after window", rs[m], 57);
  endtask

  task automatic t_chain(input int m);
    int cyc;
    longint val;
    do_op(m, 8'sd2, 8'sd3, 8'sd4, cyc, val);
    check(val == -23, "R8", "first of pair", val, -23);
    do_op(m, -8'sd3, 8'sd4, -8'sd5, cyc, val);
    check(val == -44, "R8", "second of pair", val, -44);
    check(cyc == exp_lat(m), "R8", "second latency", cyc, exp_lat(m));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++) begin
      t_values(m);
      t_ignore(m);
      t_chain(m);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule